// File: doc/BRIEF.md
# Serial register monitor output

This block sends the value of one internal 16-bit signal-path register out of a single serial line, one word per symbol period. It runs on a bit clock at sixteen times the symbol rate. A symbol-rate strobe arrives on a separate input that is asynchronous to the bit clock. On each rising edge of that strobe the block samples the chosen register into a holding register. It then shifts the word out least significant bit first, so one word fills one symbol period exactly.

A small configuration write port holds a source select code. It is made of an address, a write-data byte and a write-enable. The select code picks one of up to eight sources. Because the select code is only used at the capture instant, a change of source always starts on a word boundary. If the strobe stops, the line goes quiet and stays low until the next symbol edge.

Top module: `smon_top`

## Requirements
- R1: Each word is 16 bits, sent least significant bit first, one bit per bit-clock cycle, so 16 consecutive bit periods carry one whole word.
- R2: A word starts from the symbol edge. The least significant bit appears on `mon_out` after the third rising bit-clock edge that follows the rise of `sym_clk`: two edges for the synchroniser and one for the capture. Words from back-to-back symbols leave no gap.
- R3: The word is frozen at capture. A change of any source value during a word does not alter the bits still to be sent.
- R4: The select code is bits [2:0] of the byte written to configuration address 0x01. Upper data bits are ignored. Code k selects `src_words[16k+15:16k]`.
- R5: A select write made during a word does not affect that word. It takes effect from the next word.
- R6: A write to any configuration address other than 0x01 leaves the select code unchanged.
- R7: After reset `mon_out` is low and the select code is 0. No word is sent until the first `sym_clk` rising edge.
- R8: When 16 bits have been sent and no new symbol edge has arrived, `mon_out` returns low and stays low until the next symbol edge.
- R9: A select code equal to or above NUM_SRC (codes 6 and 7 by default) sends an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, sixteen times the symbol rate |
| rst | input | 1 | Synchronous active-high reset |
| sym_clk | input | 1 | Symbol-rate strobe, asynchronous to `clk` |
| src_words | input | NUM_SRC*16 (96) | Monitored registers, source k in bits [16k+15:16k] |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| mon_out | output | 1 | Serial monitor output |

## Verification
The hardest cases to reach from the ports are those where something changes while a word is in flight: a select write, a write to a foreign address, or a change in the source values. Each must land after the capture instant and before bit 15, and it must be shown to touch only the words that follow. The driver raises and lowers `sym_clk` on a fixed 16-cycle grid and fires these changes in the middle of the high phase. For each symbol it queues the word that was due at the edge, with the bit-clock cycle where that word should start. The monitor then compares every bit period, including the idle periods before the first edge and during a deliberate pause in the strobe.

// File: rtl/smon_pkg.sv
package smon_pkg;

    localparam int WORD_W     = 16;
    localparam int SEL_W      = 3;
    localparam int CFG_ADDR_W = 8;
    localparam int CFG_DATA_W = 8;
    localparam int BIT_CNT_W  = $clog2(WORD_W);
    localparam int SEL_CODES  = 2 ** SEL_W;

    localparam logic [CFG_ADDR_W-1:0] SEL_REG_ADDR = 8'h01;

    typedef logic [WORD_W-1:0] mon_word_t;
    typedef logic [SEL_W-1:0]  sel_code_t;

    typedef enum logic [0:0] {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_mode_t;

    typedef struct packed {
        ser_mode_t              mode;
        logic [BIT_CNT_W-1:0]   bitpos;
        mon_word_t              shadow;
        logic                   line;
    } ser_state_t;

    function automatic logic is_last_bit(input logic [BIT_CNT_W-1:0] pos);
        return pos == BIT_CNT_W'(WORD_W - 1);
    endfunction

endpackage

// File: rtl/smon_edge_sync.sv
module smon_edge_sync
    import smon_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R2: a detected edge is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/smon_src_sel.sv
module smon_src_sel
    import smon_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CFG_ADDR_W-1:0]         cfg_addr,
    input  logic [CFG_DATA_W-1:0]         cfg_wdata,
    input  logic [NUM_SRC*WORD_W-1:0]     src_words,
    output mon_word_t                     sel_word
);

    sel_code_t sel_q;
    mon_word_t choices [SEL_CODES];

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (cfg_we && cfg_addr == SEL_REG_ADDR)
            sel_q <= cfg_wdata[SEL_W-1:0];
    end

    for (genvar g = 0; g < SEL_CODES; g++) begin : g_choice
        if (g < NUM_SRC) begin : g_real
            assign choices[g] = src_words[g*WORD_W +: WORD_W];
        end else begin : g_empty
            assign choices[g] = '0;
        end
    end

    assign sel_word = choices[sel_q];

    // R6: foreign addresses never alter the select code
    a_r6_foreign_addr: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr != SEL_REG_ADDR) |=> $stable(sel_q));

    // R4: a matching write loads the low data bits
    a_r4_sel_load: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == SEL_REG_ADDR) |=> sel_q == $past(cfg_wdata[SEL_W-1:0]));

endmodule

// File: rtl/smon_serializer.sv
module smon_serializer
    import smon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sym_rise,
    input  mon_word_t word_in,
    output logic      line_out
);

    ser_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (sym_rise) begin
            st.mode   <= SER_SEND;
            st.bitpos <= '0;
            st.shadow <= word_in;
            st.line   <= word_in[0];
        end else if (st.mode == SER_SEND) begin
            if (is_last_bit(st.bitpos)) begin
                st.mode <= SER_IDLE;
                st.line <= 1'b0;
            end else begin
                st.bitpos <= st.bitpos + 1'b1;
                st.line   <= st.shadow[st.bitpos + 1'b1];
            end
        end
    end

    assign line_out = st.line;

    // R2: a symbol edge restarts the word at bit 0
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        sym_rise |=> (st.mode == SER_SEND && st.bitpos == '0));

    // R1: the bit position steps by one through the word
    a_r1_bit_step: assert property (@(posedge clk) disable iff (rst)
        (st.mode == SER_SEND && !sym_rise && !is_last_bit(st.bitpos))
            |=> st.bitpos == $past(st.bitpos) + 1'b1);

    // R3: the captured word stays frozen between symbol edges
    a_r3_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        !sym_rise |=> $stable(st.shadow));

    // R8: after the last bit without a new edge the line is low
    a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
        (st.mode == SER_SEND && is_last_bit(st.bitpos) && !sym_rise) |=> !line_out);

endmodule

// File: rtl/smon_top.sv
module smon_top
    import smon_pkg::*;
#(
    parameter int NUM_SRC     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sym_clk,
    input  logic [NUM_SRC*WORD_W-1:0]     src_words,
    input  logic                          cfg_we,
    input  logic [CFG_ADDR_W-1:0]         cfg_addr,
    input  logic [CFG_DATA_W-1:0]         cfg_wdata,
    output logic                          mon_out
);

    logic      sym_rise;
    mon_word_t sel_word;

    smon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sym_clk),
        .rise     (sym_rise)
    );

    smon_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .src_words (src_words),
        .sel_word  (sel_word)
    );

    smon_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .sym_rise (sym_rise),
        .word_in  (sel_word),
        .line_out (mon_out)
    );

    // R7: the line stays low while reset is held
    a_r7_reset_low: assert property (@(posedge clk)
        rst |=> !mon_out);

endmodule

// File: tb/test_smon_top.sv
module test_smon_top;

    localparam int CLK_T   = 10;
    localparam int NSRC    = 6;
    localparam int LATENCY = 3;

    typedef struct {
        int          start;
        logic [15:0] word;
        string       tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sym_clk = 1'b0;
    logic [NSRC*16-1:0] src_words = '0;
    logic               cfg_we = 1'b0;
    logic [7:0]         cfg_addr = '0;
    logic [7:0]         cfg_wdata = '0;
    logic               mon_out;

    smon_top #(.NUM_SRC(NSRC)) i_smon_top (
        .clk       (clk),
        .rst       (rst),
        .sym_clk   (sym_clk),
        .src_words (src_words),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mon_out   (mon_out)
    );

    always #(CLK_T/2) clk = ~clk;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    logic mon_en = 1'b0;
    logic [2:0] sel_m = 3'd0;
    exp_t q[$];

    always @(posedge clk) cyc++;

    task automatic check(input logic ok, input string tag, input logic act, input logic expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: mon_out=%0b expected %0b", tag, cyc, act, expv);
        end
    endtask

    // monitor: compares every bit period against the scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            if (q.size() > 0 && cyc >= q[0].start) begin
                int b;
                b = cyc - q[0].start;
                check(mon_out === q[0].word[b], q[0].tag, mon_out, q[0].word[b]);
                if (b == 15) void'(q.pop_front());
            end else begin
                check(mon_out === 1'b0, "R7/R8 idle line low", mon_out, 1'b0);
            end
        end
    end

    function automatic logic [15:0] model_word();
        if (sel_m < NSRC) return src_words[sel_m*16 +: 16];
        return 16'h0000;
    endfunction

    // one symbol period of 16 bit clocks with optional mid-word events
    task automatic send_sym(input string tag, input bit mid_src, input bit mid_wr,
                            input logic [7:0] waddr, input logic [7:0] wdata);
        exp_t e;
        @(negedge clk);
        sym_clk = 1'b1;
        e.start = cyc + LATENCY;
        e.word  = model_word();
        e.tag   = tag;
        q.push_back(e);
        repeat (4) @(negedge clk);
        if (mid_src) src_words = ~src_words;
        if (mid_wr) begin
            cfg_we = 1'b1; cfg_addr = waddr; cfg_wdata = wdata;
            if (waddr == 8'h01) sel_m = wdata[2:0];
        end
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        sym_clk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_T * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSRC; i++)
            src_words[i*16 +: 16] = 16'h8001 ^ (16'(i) * 16'h1357) ^ (16'h0F00 >> i);
        repeat (4) @(negedge clk);
        check(mon_out === 1'b0, "R7 output low in reset", mon_out, 1'b0);
        rst = 1'b0;
        mon_en = 1'b1;
        // R7: no word before first symbol edge
        repeat (20) @(negedge clk);
        // R7 default select 0, R1 framing, R2 back-to-back alignment
        send_sym("R7 default source 0", 0, 0, 8'h00, 8'h00);
        send_sym("R1 word lsb first", 0, 0, 8'h00, 8'h00);
        // R5: select write mid-word; upper bits ignored (R4)
        send_sym("R5 old select holds", 0, 1, 8'h01, 8'hF3);
        send_sym("R4 select code 3", 0, 0, 8'h00, 8'h00);
        // R6: foreign address write
        send_sym("R6 foreign addr", 0, 1, 8'h02, 8'h05);
        send_sym("R6 select unchanged", 0, 1, 8'h81, 8'h04);
        // R3: sources flip mid-word
        send_sym("R3 frozen word", 1, 0, 8'h00, 8'h00);
        send_sym("R3 new value next word", 0, 1, 8'h01, 8'h06);
        send_sym("R9 code 6 zeros", 0, 1, 8'h01, 8'h07);
        send_sym("R9 code 7 zeros", 0, 1, 8'h01, 8'h05);
        send_sym("R4 select code 5", 0, 0, 8'h00, 8'h00);
        // R8: pause in the strobe
        repeat (40) @(negedge clk);
        send_sym("R8 resume after pause", 1, 1, 8'h01, 8'h01);
        send_sym("R2 alignment after pause", 0, 0, 8'h00, 8'h00);
        repeat (30) @(negedge clk);
        if (q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R1 %0d words not seen, expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule